// File: doc/BRIEF.md
# Pixel-Rate Reset and Correlated-Double-Sampling Strobe Generator

This block produces the per-pixel timing for the serial readout of an interline image sensor. It runs from a reference clock at eight times the pixel rate. A three-bit phase counter divides each pixel period into eight slots, and the block decodes the counter into two complementary horizontal transfer clocks, the output-node reset pulse, and the clamp and sample strobes that drive an off-chip correlated double sampler. The sampler and the converter are outside this block.

Within each pixel the order is fixed:
1. Phase-2 rises at phase 0, and the reset pulse rises in the same cycle.
2. The clamp strobe captures the reference level while phase-2 is high.
3. Phase-2 falls at the half-period boundary, and this fall dumps the charge onto the output node.
4. The sample strobe captures the signal level after that fall.

The reset length and the clamp and sample slots can be programmed. A configuration write that would break this order is discarded. A line sequencer gates the block with a run enable. While the enable is low, the clocks sit at their idle levels. When the enable returns, the next pixel starts at phase 0.

Top module: `pxg_top`

## Requirements
- R1: After reset the outputs are idle: `hclk1`=1, `hclk2`=0, and `node_rst`, `clamp_stb` and `sample_stb` are 0. The active configuration is reset length 1, clamp slot 2 and sample slot 6.
- R2: While `run_en` is high, the phase advances by one on every clock and wraps from 7 to 0, so one pixel is 8 clocks. `hclk2` is high in phases 0 to 3 and low in phases 4 to 7, and `hclk1` is always its complement. Each output shows the phase that was current at the previous clock edge (one register of latency).
- R3: `node_rst` is high in the phases p with p < reset length. It therefore rises in the same cycle as `hclk2`.
- R4: `clamp_stb` is high for exactly one clock per pixel, in the clamp slot.
- R5: `sample_stb` is high for exactly one clock per pixel, in the sample slot. At most one of `node_rst`, `clamp_stb` and `sample_stb` is high in any cycle.
- R6: One clock after `run_en` is sampled low, all outputs are idle as in R1. When `run_en` is sampled high again, the first output pixel begins at phase 0.
- R7: A write (`cfg_wr`=1) is accepted only if all of the following hold:
  - reset length ≥ 1;
  - reset length ≤ clamp slot;
  - clamp slot < 4 (before the `hclk2` fall);
  - sample slot > 4 (after the fall).

  Any other write is discarded, and the previous configuration stays in effect.
- R8: An accepted write is staged. It becomes active at the next pixel boundary, so the pixel that starts after the first clock at which the counter sits at phase 7 uses it. While the block is idle, the staged value becomes active on the next clock. A pixel never mixes an old and a new configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, 8× pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_en | input | 1 | Run gate from the line sequencer |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rst_len | input | 3 | Reset pulse length in phases |
| cfg_clamp | input | 3 | Clamp strobe phase slot |
| cfg_sample | input | 3 | Sample strobe phase slot |
| hclk1 | output | 1 | Horizontal phase-1 clock |
| hclk2 | output | 1 | Horizontal phase-2 clock |
| node_rst | output | 1 | Output-node reset pulse |
| clamp_stb | output | 1 | Reference-level clamp strobe |
| sample_stb | output | 1 | Signal-level sample strobe |

## Verification
A configuration write can land in the same clock in which the active setting reloads at a pixel boundary. The staged value must then be captured for the following load, and the outgoing pixel must keep its old slots. The bench provokes this by issuing the write exactly when its own phase tracker reads 7, and again while the block is idle. Its behavioural model predicts, per clock, which setting each pixel uses, and every output is compared against that prediction on every clock. The same model checks a run enable dropped in the middle of a pixel, followed by a restart.

// File: rtl/pxg_pkg.sv
package pxg_pkg;
  localparam int PH_W = 3;
  localparam int NPH  = 1 << PH_W;

  typedef logic [PH_W-1:0] phase_t;

  typedef struct packed {
    phase_t rst_len;
    phase_t clamp_at;
    phase_t sample_at;
  } slot_cfg_t;
endpackage

// File: rtl/pxg_phase_ctr.sv
module pxg_phase_ctr
  import pxg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run_en,
  output phase_t phase,
  output logic   wrap
);
  phase_t ph_q, ph_d;

  always_comb begin
    if (run_en) ph_d = ph_q + 1'b1;
    else        ph_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign phase = ph_q;
  assign wrap  = (ph_q == phase_t'(NPH - 1));

  // R6: a stopped counter restarts from slot zero
  p_restart_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (phase == '0));

  // R2: one slot per clock while running
  p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && $past(run_en) && $past(phase) != phase_t'(NPH - 1))
      |-> (phase > $past(phase)));
endmodule

// File: rtl/pxg_cfg_stage.sv
module pxg_cfg_stage
  import pxg_pkg::*;
#(
  parameter int        H2_FALL = NPH / 2,
  parameter slot_cfg_t DEF_CFG = '{rst_len: 3'd1, clamp_at: 3'd2, sample_at: 3'd6}
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr,
  input  slot_cfg_t wr_cfg,
  input  logic      load,
  output slot_cfg_t active
);
  slot_cfg_t staged_q, staged_d;
  slot_cfg_t active_q, active_d;
  logic      legal;

  always_comb begin
    legal = (wr_cfg.rst_len != '0) &&
            (wr_cfg.clamp_at >= wr_cfg.rst_len) &&
            (wr_cfg.clamp_at < phase_t'(H2_FALL)) &&
            (wr_cfg.sample_at > phase_t'(H2_FALL));
    staged_d = (wr && legal) ? wr_cfg : staged_q;
    active_d = load ? staged_q : active_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged_q <= DEF_CFG;
      active_q <= DEF_CFG;
    end else begin
      staged_q <= staged_d;
      active_q <= active_d;
    end
  end

  assign active = active_q;

  // R7: only ordered settings ever become active
  p_active_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active.rst_len != '0) && (active.clamp_at >= active.rst_len) &&
    (active.clamp_at < phase_t'(H2_FALL)) && (active.sample_at > phase_t'(H2_FALL)));

  // R8: the setting never changes inside a pixel
  p_hold_mid_pixel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(active));
endmodule

// File: rtl/pxg_strobe_dec.sv
module pxg_strobe_dec
  import pxg_pkg::*;
#(
  parameter int H2_FALL = NPH / 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run_en,
  input  phase_t    phase,
  input  slot_cfg_t cfg,
  output logic      hclk1,
  output logic      hclk2,
  output logic      node_rst,
  output logic      clamp_stb,
  output logic      sample_stb
);
  logic h1_d, h2_d, rs_d, cl_d, sm_d;
  logic h1_q, h2_q, rs_q, cl_q, sm_q;

  always_comb begin
    if (run_en) begin
      h2_d = (phase < phase_t'(H2_FALL));
      h1_d = ~h2_d;
      rs_d = (phase < cfg.rst_len);
      cl_d = (phase == cfg.clamp_at);
      sm_d = (phase == cfg.sample_at);
    end else begin
      h1_d = 1'b1;
      h2_d = 1'b0;
      rs_d = 1'b0;
      cl_d = 1'b0;
      sm_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1_q <= 1'b1;
      h2_q <= 1'b0;
      rs_q <= 1'b0;
      cl_q <= 1'b0;
      sm_q <= 1'b0;
    end else begin
      h1_q <= h1_d;
      h2_q <= h2_d;
      rs_q <= rs_d;
      cl_q <= cl_d;
      sm_q <= sm_d;
    end
  end

  assign hclk1      = h1_q;
  assign hclk2      = h2_q;
  assign node_rst   = rs_q;
  assign clamp_stb  = cl_q;
  assign sample_stb = sm_q;

  // R2: horizontal clocks stay complementary
  p_complement_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hclk1 != hclk2);

  // R3: node reset accompanies every phase-2 rise
  p_rst_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hclk2) |-> node_rst);

  // R4: clamp falls in the reference window
  p_clamp_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_stb |-> (hclk2 && !node_rst));

  // R5: sample only after the charge dump
  p_sample_after_dump_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> !hclk2);

  // R5: strobes never overlap
  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({node_rst, clamp_stb, sample_stb}));

  // R6: idle levels follow a stop
  p_idle_levels_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (hclk1 && !hclk2 && !node_rst && !clamp_stb && !sample_stb));
endmodule

// File: rtl/pxg_top.sv
module pxg_top
  import pxg_pkg::*;
#(
  parameter int H2_FALL     = NPH / 2,
  parameter int DEF_RST_LEN = 1,
  parameter int DEF_CLAMP   = 2,
  parameter int DEF_SAMPLE  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             cfg_wr,
  input  logic [PH_W-1:0]  cfg_rst_len,
  input  logic [PH_W-1:0]  cfg_clamp,
  input  logic [PH_W-1:0]  cfg_sample,
  output logic             hclk1,
  output logic             hclk2,
  output logic             node_rst,
  output logic             clamp_stb,
  output logic             sample_stb
);
  localparam slot_cfg_t DEF_CFG = '{
    rst_len:   phase_t'(DEF_RST_LEN),
    clamp_at:  phase_t'(DEF_CLAMP),
    sample_at: phase_t'(DEF_SAMPLE)
  };

  logic [1:0] sync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign srst_n = sync_q[1];

  phase_t    phase;
  logic      wrap;
  logic      load;
  slot_cfg_t wr_cfg;
  slot_cfg_t active;

  assign wr_cfg = '{rst_len: cfg_rst_len, clamp_at: cfg_clamp, sample_at: cfg_sample};
  assign load   = !run_en || wrap;

  pxg_phase_ctr u_ctr (
    .clk    (clk),
    .rst_n  (srst_n),
    .run_en (run_en),
    .phase  (phase),
    .wrap   (wrap)
  );

  pxg_cfg_stage #(
    .H2_FALL (H2_FALL),
    .DEF_CFG (DEF_CFG)
  ) u_cfg (
    .clk    (clk),
    .rst_n  (srst_n),
    .wr     (cfg_wr),
    .wr_cfg (wr_cfg),
    .load   (load),
    .active (active)
  );

  pxg_strobe_dec #(
    .H2_FALL (H2_FALL)
  ) u_dec (
    .clk        (clk),
    .rst_n      (srst_n),
    .run_en     (run_en),
    .phase      (phase),
    .cfg        (active),
    .hclk1      (hclk1),
    .hclk2      (hclk2),
    .node_rst   (node_rst),
    .clamp_stb  (clamp_stb),
    .sample_stb (sample_stb)
  );
endmodule

// File: tb/tb_pxg_top.sv
module tb_pxg_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0;
  logic cfg_wr = 1'b0;
  logic [2:0] cfg_rst_len = 3'd0;
  logic [2:0] cfg_clamp = 3'd0;
  logic [2:0] cfg_sample = 3'd0;
  logic hclk1, hclk2, node_rst, clamp_stb, sample_stb;

  always #2 clk = ~clk;

  pxg_top dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_wr(cfg_wr),
    .cfg_rst_len(cfg_rst_len), .cfg_clamp(cfg_clamp), .cfg_sample(cfg_sample),
    .hclk1(hclk1), .hclk2(hclk2), .node_rst(node_rst),
    .clamp_stb(clamp_stb), .sample_stb(sample_stb)
  );

  // behavioural reference
  int m_ph = 0;
  int a_rl = 1, a_cl = 2, a_sm = 6;
  int s_rl = 1, s_cl = 2, s_sm = 6;
  bit e_h1 = 1, e_h2 = 0, e_rs = 0, e_cl = 0, e_sm = 0;
  string scen = "R1";
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  function automatic bit legal(int rl, int cl, int sm);
    return (rl >= 1) && (cl >= rl) && (cl < 4) && (sm > 4);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; a_rl = 1; a_cl = 2; a_sm = 6; s_rl = 1; s_cl = 2; s_sm = 6;
      e_h1 = 1; e_h2 = 0; e_rs = 0; e_cl = 0; e_sm = 0;
    end else begin
      bit ld;
      if (run_en) begin
        e_h2 = (m_ph < 4); e_h1 = !e_h2;
        e_rs = (m_ph < a_rl); e_cl = (m_ph == a_cl); e_sm = (m_ph == a_sm);
      end else begin
        e_h1 = 1; e_h2 = 0; e_rs = 0; e_cl = 0; e_sm = 0;
      end
      ld = !run_en || (m_ph == 7);
      if (ld) begin a_rl = s_rl; a_cl = s_cl; a_sm = s_sm; end
      if (cfg_wr && legal(cfg_rst_len, cfg_clamp, cfg_sample)) begin
        s_rl = cfg_rst_len; s_cl = cfg_clamp; s_sm = cfg_sample;
      end
      m_ph = run_en ? (m_ph + 1) % 8 : 0;
    end
  end

  task automatic chk(bit act, bit exp, string req, string nm);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s/%s %s at %0t: actual %0b expected %0b", scen, req, nm, $time, act, exp);
    end
  endtask

  // compared every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk(hclk1, e_h1, "R2", "hclk1");
      chk(hclk2, e_h2, "R2", "hclk2");
      chk(node_rst, e_rs, "R3", "node_rst");
      chk(clamp_stb, e_cl, "R4", "clamp_stb");
      chk(sample_stb, e_sm, "R5", "sample_stb");
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ph(int p);
    @(negedge clk);
    while (m_ph != p) @(negedge clk);
  endtask

  task automatic write_cfg(int rl, int cl, int sm);
    cfg_wr = 1; cfg_rst_len = 3'(rl); cfg_clamp = 3'(cl); cfg_sample = 3'(sm);
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    // R1: idle levels and defaults through reset
    scen = "R1";
    cycles(4);
    rst_n = 1;
    cycles(5);
    // R2..R5: default slots over several pixels
    scen = "R2";
    run_en = 1;
    cycles(40);
    // R8: mid-pixel write waits for boundary
    scen = "R8";
    wait_ph(3);
    write_cfg(2, 3, 5);
    cycles(24);
    // R7: illegal writes are dropped
    scen = "R7";
    write_cfg(1, 4, 6); cycles(10);
    write_cfg(1, 2, 4); cycles(10);
    write_cfg(0, 2, 6); cycles(10);
    write_cfg(3, 2, 6); cycles(10);
    write_cfg(1, 3, 3); cycles(12);
    // R6: stop mid-pixel and restart
    scen = "R6";
    wait_ph(5);
    run_en = 0;
    cycles(6);
    run_en = 1;
    cycles(20);
    // R8: write lands on the boundary cycle
    scen = "R8";
    wait_ph(7);
    write_cfg(3, 3, 7);
    cycles(24);
    // R6: write while idle applies from the first pixel
    scen = "R6";
    run_en = 0;
    cycles(2);
    write_cfg(1, 1, 5);
    cycles(3);
    run_en = 1;
    cycles(24);
    // R5: sample in the last slot
    scen = "R5";
    write_cfg(1, 3, 7);
    cycles(24);
    finish_run();
  end
endmodule